// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a 10-bit successive-approximation search. It drives the trial code of an external binary-weighted DAC and reads back a single comparator decision. The comparator reports whether the DAC summing node sits above its trip point. The block resolves one bit per internal clock, starting at the heaviest weight and ending at weight 1. It then writes the final code into a held result register and raises a one-cycle done pulse.

The controlling logic raises `start_i` once the analog sample is held. The sequencer then runs on its own for eleven clocks: ten decisions and one step that commits the result. Raising `abort_i` during a run drops the search at once. The previously committed result stays in the register.

The comparator input is registered before it is used. The decision for a bit is therefore applied in the cycle after that bit was presented, and that same cycle also presents the next bit under test. This keeps the rate at one bit per clock.

Top module: `sar_sequencer`

## Requirements
- R1: An accepted start is a clock edge with `busy_o` low, `start_i` high and `abort_i` low. In the k-th cycle after that edge (k = 1..10), `busy_o` is high and the bit under test in `trial_o` is bit 10−k. The weights 512, 256, … 1 are therefore tested in that order, one per clock.
- R2: In each of those cycles, the bit under test is 1 and every bit below it is 0. Bits above it hold the values already decided.
- R3: When `cmp_above_i` is 1 for a presented trial (summing node above the trip point), that bit is 0 in every later trial code and in the result.
- R4: When `cmp_above_i` is 0 for a presented trial, that bit stays 1 in every later trial code and in the result.
- R5: `busy_o` stays high in cycle 11. In cycle 12, `result_o` holds the final code, `done_o` is high for exactly that one cycle, and `busy_o` is low.
- R6: A clock edge with `busy_o` and `abort_i` both high returns the sequencer to idle (`busy_o` low from the next cycle). No done pulse follows, and `result_o` keeps its prior value.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running conversion keeps its timing and its result.
- R8: With a comparator fed by an ideal DAC, an input at or above full scale yields 1023 (all ones). An input at or below zero yields 0.
- R9: Synchronous active-low reset clears `result_o`, `trial_o`, `busy_o` and `done_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a conversion (sample is held) |
| abort_i | input | 1 | Cancel a running conversion |
| cmp_above_i | input | 1 | Comparator: summing node above trip point |
| trial_o | output | 10 | Trial code driving the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is committed |
| result_o | output | 10 | Last committed conversion result |

## Verification
Several properties are checked on every cycle:
- the bit-walk order, including the MSB-first launch;
- that the bits below the one under test stay clear;
- that an abort always reaches idle on the next edge;
- that the done pulse lasts one cycle;
- that the result changes only together with done.

The arithmetic correctness of the search is shown only by the bench scenarios. These include every one of the 1024 codes, inputs beyond both rails, a restart during a run, and aborts at the middle and the last decision. In each scenario an ideal DAC model predicts every intermediate trial code and the final result.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
package sar_pkg;
    // Sequencer phase: idle, deciding bits, committing the result.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FINAL = 2'd2
    } phase_t;
endpackage

// File: rtl/sar_cmp_reg.sv
// Registers the asynchronous-looking comparator decision.
// Assumes: the comparator output settles within one clock of a trial change.
module sar_cmp_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    output logic cmp_q_o
);
    // Capture the decision for the trial presented in the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q_o <= 1'b0;
        else        cmp_q_o <= cmp_i;
    end
endmodule

// File: rtl/sar_bit_walker.sv
// Phase control and one-hot pointer to the bit under test.
// Assumes: start and abort are synchronous to clk; abort has priority.
module sar_bit_walker
    import sar_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         abort_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] prev_mask_o,
    output logic         launch_o,
    output logic         busy_o,
    output logic         final_o
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    phase_t       phase_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] prev_q;

    // Decode the phase into control strobes.
    always_comb begin
        busy_o   = (phase_q != PH_IDLE);
        launch_o = (phase_q == PH_IDLE) && start_i && !abort_i;
        final_o  = (phase_q == PH_FINAL) && !abort_i;
    end

    // Advance the pointer one weight per clock and sequence the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mask_q  <= '0;
            prev_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (launch_o) begin
                        phase_q <= PH_RUN;
                        mask_q  <= TOP_BIT;
                        prev_q  <= '0;
                    end
                end
                PH_RUN: begin
                    if (abort_i) begin
                        phase_q <= PH_IDLE;
                        mask_q  <= '0;
                        prev_q  <= '0;
                    end else begin
                        prev_q <= mask_q;
                        mask_q <= mask_q >> 1;
                        if (mask_q[0]) phase_q <= PH_FINAL;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    mask_q  <= '0;
                    prev_q  <= '0;
                end
            endcase
        end
    end

    assign mask_o      = mask_q;
    assign prev_mask_o = prev_q;

    // R1
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && !abort_i) |=> (mask_q == ($past(mask_q) >> 1)));
    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> !busy_o);
endmodule

// File: rtl/sar_code_reg.sv
// Holds the decided bits and forms the trial code for the DAC.
// Assumes: the registered comparator bit refers to the bit tested last cycle.
module sar_code_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         busy_i,
    input  logic         cmp_q_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] prev_mask_i,
    output logic [W-1:0] trial_o
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_q;
    logic [W-1:0] resolved;

    // Apply last cycle's decision: node above trip point removes that weight.
    always_comb begin
        resolved = cmp_q_i ? (code_q & ~prev_mask_i) : code_q;
        trial_o  = resolved | mask_i;
    end

    // Keep the resolved bits while the search runs; clear on launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (clear_i) code_q <= '0;
        else if (busy_i)  code_q <= trial_o;
    end

    // R1
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> (trial_o == TOP_BIT));
    // R2
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && mask_i != '0) |-> ((trial_o & (mask_i - 1'b1)) == '0));
endmodule

// File: rtl/sar_result_reg.sv
// Output data register and done pulse.
// Assumes: commit is asserted for at most one cycle per conversion.
module sar_result_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);
    // Latch the final code and pulse done in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= commit_i;
            if (commit_i) result_o <= code_i;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

// File: rtl/sar_sequencer.sv
// Top of the successive-approximation sequencer: one bit decision per clock,
// MSB first, result committed with a single-cycle done pulse.
// Assumes: external DAC and comparator; cmp_above_i high means node above trip.
module sar_sequencer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         abort_i,
    input  logic         cmp_above_i,
    output logic [W-1:0] trial_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    logic [W-1:0] mask;
    logic [W-1:0] prev_mask;
    logic         launch;
    logic         commit;
    logic         cmp_q;

    sar_cmp_reg u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_i   (cmp_above_i),
        .cmp_q_o (cmp_q)
    );

    sar_bit_walker #(.W(W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .mask_o      (mask),
        .prev_mask_o (prev_mask),
        .launch_o    (launch),
        .busy_o      (busy_o),
        .final_o     (commit)
    );

    sar_code_reg #(.W(W)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (launch),
        .busy_i      (busy_o),
        .cmp_q_i     (cmp_q),
        .mask_i      (mask),
        .prev_mask_i (prev_mask),
        .trial_o     (trial_o)
    );

    sar_result_reg #(.W(W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (trial_o),
        .result_o (result_o),
        .done_o   (done_o)
    );
endmodule

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
    localparam int W    = 10;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         abort = 1'b0;
    logic         cmp;
    logic [W-1:0] trial;
    logic [W-1:0] result;
    logic         busy;
    logic         done;
    int           vin = 0;
    int           checks = 0;
    int           fails = 0;
    bit           finished = 1'b0;

    always #10 clk = ~clk;

    // Ideal DAC and comparator: node above trip when trial exceeds input.
    assign cmp = (int'(trial) > vin);

    sar_sequencer #(.W(W)) i_sar_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .abort_i     (abort),
        .cmp_above_i (cmp),
        .trial_o     (trial),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < 0) return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    // Run one conversion; restart_at pulses start while busy, abort_at aborts.
    task automatic convert(input int v, input int restart_at, input int abort_at,
                           input int prior, input string tag);
        int exp;
        vin = v;
        exp = clampv(v);
        @(negedge clk);
        start = 1'b1;
        for (int k = 1; k <= W; k++) begin
            int p;
            int etrial;
            @(negedge clk);
            p = W - k;
            etrial = (exp & ~((1 << (p + 1)) - 1)) | (1 << p);
            // R1 busy through decisions
            chk(busy == 1'b1, "R1 busy", int'(busy), 1);
            // R2 R3 R4 trial code per step
            chk(int'(trial) == etrial, "R2/R3/R4 trial", int'(trial), etrial);
            start = (k == restart_at);
            abort = (k == abort_at);
            if (k == abort_at) begin
                @(negedge clk);
                abort = 1'b0;
                chk(busy == 1'b0, "R6 idle", int'(busy), 0);
                for (int j = 0; j < 13; j++) begin
                    @(negedge clk);
                    chk(done == 1'b0, "R6 no done", int'(done), 0);
                end
                chk(int'(result) == prior, "R6 result kept", int'(result), prior);
                return;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R5 commit cycle", int'({busy, done}), 2);
        @(negedge clk);
        chk(done == 1'b1, "R5 done", int'(done), 1);
        chk(int'(result) == exp, tag, int'(result), exp);
        chk(busy == 1'b0, "R5 idle", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(result == '0, "R9 result", int'(result), 0);
        chk(trial == '0, "R9 trial", int'(trial), 0);
        chk(busy == 1'b0 && done == 1'b0, "R9 flags", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v <= FULL; v++) convert(v, 0, 0, 0, "R5 result");
        // R8 rails
        convert(FULL + 50, 0, 0, 0, "R8 above full scale");
        convert(-7, 0, 0, 0, "R8 below zero");
        convert(FULL, 0, 0, 0, "R8 full scale");
        convert(0, 0, 0, 0, "R8 zero");
        // R6 abort mid-run and on the last decision
        convert(300, 0, 0, 0, "R5 result");
        convert(700, 0, 5, 300, "R6");
        convert(900, 0, 10, 300, "R6");
        // R7 start while busy
        convert(555, 4, 0, 0, "R7 result after restart");
        convert(42, 9, 0, 0, "R7 result after restart");
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule